// File: doc/BRIEF.md
# Two-Level Exclusive Access Monitor

This block gives two bus masters a shared way to claim memory with load-exclusive and store-exclusive pairs. Each master has its own local monitor. A global monitor holds one entry per master and stands for the interconnect side. Every request names its master, an operation, an address, a shareable flag and a secure flag. The block reports the outcome one cycle later.

A store-exclusive always goes to the issuing master's local monitor first. It reaches the global monitor only when the local monitor passes, and only when the region is shareable or the force-global bit for the request's security state is set. A two-bit control register holds those force-global bits, one for secure and one for non-secure. Both bits reset to zero, so by default non-shareable memory uses only the local monitor. Tags are kept at 32-byte granule resolution.

Top module: `excl_monitor_pair`

## Requirements
- R1: Operations are encoded on `req_op` as 0 load-exclusive, 1 store-exclusive, 2 clear-exclusive and 3 ordinary store. Every accepted request produces `rsp_valid` exactly one cycle later. Only a store-exclusive can report `rsp_fail`=1. An ordinary store reports `rsp_write`=1.
- R2: A load-exclusive followed by a store-exclusive from the same master to the same granule of non-shareable memory, with force off, reports `rsp_fail`=0 and `rsp_write`=1. It reports `rsp_global`=0.
- R3: Address bits [31:5] form the tag. A store-exclusive to another byte of the claimed 32-byte granule passes. One to a different granule fails and reports `rsp_write`=0.
- R4: After any store-exclusive, whether it passed or failed, that master's local monitor and its global entry are open. A second store-exclusive then fails.
- R5: A clear-exclusive opens the issuing master's local monitor, so a following store-exclusive fails.
- R6: `rsp_global`=1 only for a store-exclusive that passed its local monitor and needs the global monitor. It needs the global monitor when shareable, or when the force bit for its security state is set. A store-exclusive that fails locally reports `rsp_global`=0.
- R7: An ordinary store by the other master to a granule held in a master's global entry clears that entry. A later shareable store-exclusive then fails with `rsp_global`=1. A store to a different granule leaves the entry in place.
- R8: A shareable store-exclusive fails when the local tag matches but the master's global entry holds a different granule.
- R9: The force bit for the request's security state makes non-shareable exclusive accesses use the global monitor. `force_bits[1]` serves secure requests and `force_bits[0]` serves non-secure ones.
- R10: When `cfg_we` is high, `cfg_force` is written into the bank chosen by `cfg_secure`. The result is visible on `force_bits` from the next cycle. Both bits reset to 0.
- R11: After reset `rsp_valid` is 0 and all monitors are open, so a store-exclusive fails.
- R12: The local monitors of the two masters are independent. One master's load-exclusive does not let the other master's store-exclusive pass.
- R13: A successful store-exclusive counts as a write. It clears the other master's global entry for the same granule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_mst | input | 1 | Issuing master index |
| req_op | input | 2 | Operation code (see R1) |
| req_addr | input | 32 | Byte address |
| req_shared | input | 1 | Region is shareable |
| req_secure | input | 1 | Request is from the secure state |
| cfg_we | input | 1 | Write one force-global bank |
| cfg_secure | input | 1 | Bank select: 1 secure, 0 non-secure |
| cfg_force | input | 1 | Value written into the selected bank |
| force_bits | output | 2 | Force-global register: [1] secure, [0] non-secure |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_fail | output | 1 | Store-exclusive status: 1 failed, 0 passed |
| rsp_write | output | 1 | Memory write is performed |
| rsp_global | output | 1 | Store-exclusive was forwarded to the global monitor |

## Verification
The hardest case to reach is a shareable store-exclusive whose local monitor still matches while its global entry is gone or stale. Only that case shows the global check acting after the local one. The bench reaches it in three ways. The other master writes the claimed granule between the load and the store. A non-shareable load-exclusive moves only the local tag. The other master completes its own exclusive pair on the same granule first. The secure force bank uses the same cross-master write, which proves that non-shareable traffic reaches the global monitor only under the matching bank.

// File: rtl/excl_monitor_pair.sv
module excl_monitor_pair #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 5,
  parameter int N_MST    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [$clog2(N_MST)-1:0] req_mst,
  input  logic [1:0]               req_op,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_shared,
  input  logic                     req_secure,
  input  logic                     cfg_we,
  input  logic                     cfg_secure,
  input  logic                     cfg_force,
  output logic [1:0]               force_bits,
  output logic                     rsp_valid,
  output logic                     rsp_fail,
  output logic                     rsp_write,
  output logic                     rsp_global
);
  localparam int TAG_W = ADDR_W - GRAN_LSB;
  localparam logic [1:0] OP_LDX = 2'd0, OP_STX = 2'd1, OP_CLR = 2'd2, OP_ST = 2'd3;

  logic [N_MST-1:0] loc_excl, glb_excl;
  logic [TAG_W-1:0] loc_tag [N_MST];
  logic [TAG_W-1:0] glb_tag [N_MST];

  wire [TAG_W-1:0] gran   = req_addr[ADDR_W-1:GRAN_LSB];
  wire             use_g  = req_shared | force_bits[req_secure];
  wire             loc_ok = loc_excl[req_mst] && (loc_tag[req_mst] == gran);
  wire             glb_ok = glb_excl[req_mst] && (glb_tag[req_mst] == gran);
  wire             is_stx = req_valid && (req_op == OP_STX);
  wire             pass   = loc_ok && (!use_g || glb_ok);
  wire             writes = req_valid && ((req_op == OP_ST) || (req_op == OP_STX && pass));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_bits <= '0;
      rsp_valid  <= 1'b0;
      rsp_fail   <= 1'b0;
      rsp_write  <= 1'b0;
      rsp_global <= 1'b0;
      loc_excl   <= '0;
      glb_excl   <= '0;
      for (int i = 0; i < N_MST; i++) begin
        loc_tag[i] <= '0;
        glb_tag[i] <= '0;
      end
    end else begin
      rsp_valid  <= req_valid;
      rsp_fail   <= is_stx && !pass;
      rsp_write  <= writes;
      rsp_global <= is_stx && use_g && loc_ok;
      if (cfg_we) force_bits[cfg_secure] <= cfg_force;
      for (int i = 0; i < N_MST; i++)
        if (writes && i != int'(req_mst) && glb_tag[i] == gran) glb_excl[i] <= 1'b0;
      if (req_valid) begin
        case (req_op)
          OP_LDX: begin
            loc_excl[req_mst] <= 1'b1;
            loc_tag[req_mst]  <= gran;
            if (use_g) begin
              glb_excl[req_mst] <= 1'b1;
              glb_tag[req_mst]  <= gran;
            end
          end
          OP_STX: begin
            loc_excl[req_mst] <= 1'b0;
            glb_excl[req_mst] <= 1'b0;
          end
          OP_CLR: loc_excl[req_mst] <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

module excl_monitor_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic       req_shared,
  input logic       req_secure,
  input logic       cfg_we,
  input logic       cfg_secure,
  input logic       cfg_force,
  input logic [1:0] force_bits,
  input logic       rsp_valid,
  input logic       rsp_fail,
  input logic       rsp_write,
  input logic       rsp_global
);
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r1_fail_only_stx: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 2'd1) |=> !rsp_fail);
  a_r3_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fail |-> !rsp_write);
  a_r6_global_only_stx: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 2'd1) |=> !rsp_global);
  a_r9_local_only: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_shared && !force_bits[req_secure]) |=> !rsp_global);
  a_r10_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> force_bits[$past(cfg_secure)] == $past(cfg_force));
endmodule

bind excl_monitor_pair excl_monitor_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_shared(req_shared), .req_secure(req_secure), .cfg_we(cfg_we),
  .cfg_secure(cfg_secure), .cfg_force(cfg_force), .force_bits(force_bits),
  .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_write(rsp_write),
  .rsp_global(rsp_global));

// File: tb/tb_excl_monitor_pair.sv
module tb_excl_monitor_pair;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_mst = 0, req_shared = 0, req_secure = 0;
  logic [1:0] req_op = 0;
  logic [31:0] req_addr = 0;
  logic cfg_we = 0, cfg_secure = 0, cfg_force = 0;
  logic [1:0] force_bits;
  logic rsp_valid, rsp_fail, rsp_write, rsp_global;
  int checks = 0, errors = 0;

  localparam logic [1:0] LDX = 2'd0, STX = 2'd1, CLR = 2'd2, ST = 2'd3;

  always #5 clk = ~clk;

  excl_monitor_pair dut (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic issue(logic m, logic [1:0] op, logic [31:0] a, logic sh, logic sec);
    @(negedge clk);
    req_valid = 1; req_mst = m; req_op = op; req_addr = a; req_shared = sh; req_secure = sec;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_rsp(string req, logic f, logic w, logic g);
    check({req, " valid"}, 32'(rsp_valid), 1);
    check({req, " fail"}, 32'(rsp_fail), 32'(f));
    check({req, " write"}, 32'(rsp_write), 32'(w));
    check({req, " global"}, 32'(rsp_global), 32'(g));
  endtask

  task automatic set_force(logic sec, logic v);
    @(negedge clk);
    cfg_we = 1; cfg_secure = sec; cfg_force = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic t_reset;
    check("R11 rsp_valid idle", 32'(rsp_valid), 0);
    check("R10 force reset", 32'(force_bits), 0);
    issue(0, STX, 32'h40, 0, 0);
    expect_rsp("R11 stx after reset", 1, 0, 0);
  endtask

  task automatic t_basic;
    issue(0, LDX, 32'h100, 0, 0);
    expect_rsp("R1 ldx", 0, 0, 0);
    issue(0, STX, 32'h11C, 0, 0);
    expect_rsp("R2 R3 stx same granule", 0, 1, 0);
    issue(0, STX, 32'h100, 0, 0);
    expect_rsp("R4 second stx", 1, 0, 0);
    issue(0, LDX, 32'h100, 0, 0);
    issue(0, STX, 32'h120, 0, 0);
    expect_rsp("R3 other granule", 1, 0, 0);
    issue(1, ST, 32'h200, 0, 0);
    expect_rsp("R1 plain store", 0, 1, 0);
  endtask

  task automatic t_clear;
    issue(0, LDX, 32'h300, 0, 0);
    issue(0, CLR, 32'h300, 0, 0);
    expect_rsp("R5 clrx", 0, 0, 0);
    issue(0, STX, 32'h300, 0, 0);
    expect_rsp("R5 stx after clrx", 1, 0, 0);
  endtask

  task automatic t_shared;
    issue(0, LDX, 32'h400, 1, 0);
    issue(1, ST, 32'h800, 1, 0);
    issue(0, STX, 32'h400, 1, 0);
    expect_rsp("R7 R6 shared pass", 0, 1, 1);
    issue(0, LDX, 32'h400, 1, 0);
    issue(1, ST, 32'h410, 1, 0);
    issue(0, STX, 32'h400, 1, 0);
    expect_rsp("R7 cleared by other store", 1, 0, 1);
    issue(0, STX, 32'h400, 1, 0);
    expect_rsp("R6 local fail not forwarded", 1, 0, 0);
  endtask

  task automatic t_gtag;
    issue(0, LDX, 32'h500, 1, 0);
    issue(0, LDX, 32'h600, 0, 0);
    issue(0, STX, 32'h600, 1, 0);
    expect_rsp("R8 global tag mismatch", 1, 0, 1);
  endtask

  task automatic t_force;
    set_force(1, 1);
    check("R10 secure bank set", 32'(force_bits), 2);
    issue(1, LDX, 32'h700, 0, 1);
    issue(0, ST, 32'h700, 0, 1);
    issue(1, STX, 32'h700, 0, 1);
    expect_rsp("R9 secure forced global", 1, 0, 1);
    issue(1, LDX, 32'h700, 0, 0);
    issue(0, ST, 32'h700, 0, 0);
    issue(1, STX, 32'h700, 0, 0);
    expect_rsp("R9 non-secure local only", 0, 1, 0);
    set_force(1, 0);
    check("R10 secure bank cleared", 32'(force_bits), 0);
  endtask

  task automatic t_indep;
    issue(1, LDX, 32'h900, 0, 0);
    issue(0, STX, 32'h900, 0, 0);
    expect_rsp("R12 other master", 1, 0, 0);
    issue(1, STX, 32'h900, 0, 0);
    expect_rsp("R12 own master", 0, 1, 0);
  endtask

  task automatic t_snoop;
    issue(0, LDX, 32'hA00, 1, 0);
    issue(1, LDX, 32'hA00, 1, 0);
    issue(1, STX, 32'hA00, 1, 0);
    expect_rsp("R13 first stx", 0, 1, 1);
    issue(0, STX, 32'hA00, 1, 0);
    expect_rsp("R13 loser stx", 1, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_clear();
    t_shared();
    t_gtag();
    t_force();
    t_indep();
    t_snoop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule